// File: doc/BRIEF.md
# Programmable-Length Loop Counter

This block is the loop filter of an all-digital first-order phase-locked loop. It is an up/down counter clocked by the fast loop clock. A phase detector output steers its direction, and a count-enable input gates it. When the count passes the top of its range going up, the block emits a one-cycle carry pulse. When it passes zero going down, it emits a one-cycle borrow pulse. Both pulses go to a downstream stage that adds or removes clock pulses.

A 4-bit length code sets the counter modulus to a power of two, and the code may change while the loop is running. A short counter gives a wide capture range and fast lock. A long counter gives a narrow bandwidth. Code zero switches counting off. The pulse output is held in a registered state with three values:

- QUIET: no pulse.
- CARRY: carry pulse this cycle.
- BORROW: borrow pulse this cycle.

On each clock the next pulse state is chosen as follows. It is CARRY on an upward wrap, BORROW on a downward wrap, and QUIET otherwise. Any state may move to any state. A synchronous reset returns the pulse state to QUIET.

Top module: `dpll_loop_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count is set to 0 and both `carry` and `borrow` are low in the following cycle.
- R2: With `len_code` = 0 the counter is switched off: `count` reads 0 and neither `carry` nor `borrow` is asserted, whatever `en` and `dir_up` are.
- R3: For a non-zero code c, the modulus is 2^(c+2). Code 1 gives 8 and code 15 gives 131072. On each rising edge with `en` high, the count moves by one: up when `dir_up` is 1, down when `dir_up` is 0.
- R4: An enabled up step from 2^(c+2)-1 sets the count to 0. `carry` is high for exactly the one cycle after that edge.
- R5: An enabled down step from 0 sets the count to 2^(c+2)-1. `borrow` is high for exactly the one cycle after that edge.
- R6: `carry` and `borrow` are never high in the same cycle. Neither output stays high for two cycles in a row.
- R7: With `en` low at an edge, the count holds and no pulse is produced.
- R8: `count` always shows the stored value reduced modulo the current modulus. A change of code therefore takes effect at once, and counting then continues from the reduced value without a spurious wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop (K) clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| len_code | input | 4 | Length code; 0 = off, c gives modulus 2^(c+2) |
| carry | output | 1 | One-cycle pulse after an upward wrap |
| borrow | output | 1 | One-cycle pulse after a downward wrap |
| count | output | 17 | Current count reduced by the current modulus |

## Verification
The bench uses the default parameters: a 4-bit code and a 3-stage shortest counter, which makes the counter 17 bits wide. At these values the modulus-8 and modulus-16 codes wrap every few steps, so random traffic produces many carries and borrows in both directions. The full 17-bit range is reached with a single down step from zero under code 15. Code changes in the middle of a count exercise the reduction to a smaller modulus, and random stimulus also exercises the switched-off code.

// File: rtl/dpll_loop_counter_pkg.sv
package dpll_loop_counter_pkg;
    typedef enum logic [1:0] {
        PS_QUIET  = 2'd0,
        PS_CARRY  = 2'd1,
        PS_BORROW = 2'd2
    } pulse_state_t;
endpackage

// File: rtl/dpll_len_mask.sv
module dpll_len_mask #(
    parameter int CODE_W     = 4,
    parameter int MIN_STAGES = 3,
    parameter int CNT_W      = MIN_STAGES + (2 ** CODE_W) - 2
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  mask,
    output logic              active
);
    localparam int OFFSET = MIN_STAGES - 1;

    assign active = (code != '0);

    for (genvar i = 0; i < CNT_W; i++) begin : g_bit
        assign mask[i] = active && (i < (int'(code) + OFFSET));
    end
endmodule

// File: rtl/dpll_count_step.sv
module dpll_count_step #(
    parameter int CNT_W = 17
) (
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] mask,
    input  logic             go,
    input  logic             up,
    output logic [CNT_W-1:0] nxt,
    output logic             wrap_up,
    output logic             wrap_dn
);
    always_comb begin
        nxt     = cur;
        wrap_up = 1'b0;
        wrap_dn = 1'b0;
        if (go) begin
            if (up) begin
                if (cur == mask) begin
                    nxt     = '0;
                    wrap_up = 1'b1;
                end else begin
                    nxt = cur + 1'b1;
                end
            end else begin
                if (cur == '0) begin
                    nxt     = mask;
                    wrap_dn = 1'b1;
                end else begin
                    nxt = cur - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dpll_loop_counter.sv
module dpll_loop_counter
    import dpll_loop_counter_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int MIN_STAGES = 3
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   en,
    input  logic                                   dir_up,
    input  logic [CODE_W-1:0]                      len_code,
    output logic                                   carry,
    output logic                                   borrow,
    output logic [MIN_STAGES+(2**CODE_W)-3:0]      count
);
    localparam int CNT_W = MIN_STAGES + (2 ** CODE_W) - 2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] nxt;
    logic             active;
    logic             wrap_up;
    logic             wrap_dn;
    pulse_state_t     state_q;
    pulse_state_t     state_d;

    dpll_len_mask #(
        .CODE_W(CODE_W),
        .MIN_STAGES(MIN_STAGES),
        .CNT_W(CNT_W)
    ) u_mask (
        .code(len_code),
        .mask(mask),
        .active(active)
    );

    assign cur = cnt_q & mask;

    dpll_count_step #(
        .CNT_W(CNT_W)
    ) u_step (
        .cur(cur),
        .mask(mask),
        .go(en && active),
        .up(dir_up),
        .nxt(nxt),
        .wrap_up(wrap_up),
        .wrap_dn(wrap_dn)
    );

    always_comb begin
        if (wrap_up)      state_d = PS_CARRY;
        else if (wrap_dn) state_d = PS_BORROW;
        else              state_d = PS_QUIET;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_QUIET;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= nxt;
        end
    end

    always_comb begin
        carry  = 1'b0;
        borrow = 1'b0;
        unique case (state_q)
            PS_QUIET:  ;
            PS_CARRY:  carry  = 1'b1;
            PS_BORROW: borrow = 1'b1;
            default:   ;
        endcase
    end

    assign count = cur;
endmodule

// File: rtl/dpll_loop_counter_chk.sv
module dpll_loop_counter_chk #(
    parameter int CODE_W     = 4,
    parameter int MIN_STAGES = 3,
    parameter int CNT_W      = MIN_STAGES + (2 ** CODE_W) - 2
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              dir_up,
    input logic [CODE_W-1:0] len_code,
    input logic              carry,
    input logic              borrow,
    input logic [CNT_W-1:0]  count
);
    logic [CNT_W-1:0] top_val;
    always_comb begin
        for (int i = 0; i < CNT_W; i++)
            top_val[i] = (len_code != '0) && (i < int'(len_code) + MIN_STAGES - 1);
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!carry && !borrow && count == '0)); // R1

    AST_OFF_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (len_code == '0) |=> (!carry && !borrow)); // R2

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(en && dir_up && len_code != '0) && $stable(len_code) && !carry)
        |-> (count == CNT_W'($past(count) + 1'b1))); // R3

    AST_CARRY_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        carry |-> (count == '0)); // R4

    AST_BORROW_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        (borrow && $past(!rst) && $stable(len_code)) |-> (count == top_val)); // R5

    AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        carry |=> !carry); // R6

    AST_BORROW_SINGLE: assert property (@(posedge clk) disable iff (rst)
        borrow |=> !borrow); // R6

    AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!en) && $stable(len_code)) |-> ($stable(count) && !carry && !borrow)); // R7
endmodule

bind dpll_loop_counter dpll_loop_counter_chk #(
    .CODE_W(CODE_W),
    .MIN_STAGES(MIN_STAGES),
    .CNT_W(CNT_W)
) u_chk (
    .clk(clk),
    .rst(rst),
    .en(en),
    .dir_up(dir_up),
    .len_code(len_code),
    .carry(carry),
    .borrow(borrow),
    .count(count)
);

// File: tb/dpll_loop_counter_test.sv
`timescale 1ns/1ps
module dpll_loop_counter_test;
    localparam int CODE_W = 4;
    localparam int MIN_STAGES = 3;
    localparam int CNT_W = MIN_STAGES + (2 ** CODE_W) - 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic dir_up = 1'b1;
    logic [CODE_W-1:0] len_code = '0;
    logic carry, borrow;
    logic [CNT_W-1:0] count;

    int checks = 0;
    int errors = 0;
    logic [CNT_W-1:0] mc = '0;
    logic exp_c = 1'b0;
    logic exp_b = 1'b0;

    always #2 clk = ~clk;

    dpll_loop_counter #(.CODE_W(CODE_W), .MIN_STAGES(MIN_STAGES)) uut (
        .clk(clk), .rst(rst), .en(en), .dir_up(dir_up), .len_code(len_code),
        .carry(carry), .borrow(borrow), .count(count)
    );

    function automatic logic [CNT_W-1:0] top_of(input logic [CODE_W-1:0] c);
        logic [CNT_W-1:0] m;
        for (int i = 0; i < CNT_W; i++) m[i] = (c != 0) && (i < int'(c) + MIN_STAGES - 1);
        return m;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_edge(input logic r, input logic e, input logic u, input logic [CODE_W-1:0] c);
        logic [CNT_W-1:0] m, cur;
        m = top_of(c);
        cur = mc & m;
        exp_c = 1'b0;
        exp_b = 1'b0;
        if (r) mc = '0;
        else if (e && c != 0) begin
            if (u) begin
                if (cur == m) begin mc = '0; exp_c = 1'b1; end
                else mc = cur + 1'b1;
            end else begin
                if (cur == 0) begin mc = m; exp_b = 1'b1; end
                else mc = cur - 1'b1;
            end
        end else mc = cur;
    endtask

    task automatic step(input logic e, input logic u, input logic [CODE_W-1:0] c,
                        input string rq_cnt, input string rq_c, input string rq_b);
        @(negedge clk);
        rst = 1'b0; en = e; dir_up = u; len_code = c;
        @(posedge clk);
        model_edge(1'b0, e, u, c);
        #1;
        check(rq_cnt, "count", count, mc & top_of(c));
        check(rq_c, "carry", carry, exp_c);
        check(rq_b, "borrow", borrow, exp_b);
        check("R6", "both", carry && borrow, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        model_edge(1'b1, en, dir_up, len_code);
        #1;
        check("R1", "count", count, 0);
        check("R1", "carry", carry, 0);
        check("R1", "borrow", borrow, 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d3a5c07));
        repeat (2) @(posedge clk);
        do_reset();
        // R2: code zero, enabled, both directions
        for (int i = 0; i < 6; i++) step(1'b1, i[0], 4'd0, "R2", "R2", "R2");
        // R3/R4: modulus 8 wrap going up
        for (int i = 0; i < 9; i++) step(1'b1, 1'b1, 4'd1, "R3", "R4", "R4");
        // R5: from 1 down through 0 at code 1
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 4'd1, "R5", "R5", "R5");
        // R7: hold with enable low
        for (int i = 0; i < 4; i++) step(1'b0, i[0], 4'd1, "R7", "R7", "R7");
        // R5: largest modulus, down from zero
        do_reset();
        step(1'b1, 1'b0, 4'd15, "R5", "R4", "R5");
        check("R5", "top15", count, 131071);
        step(1'b1, 1'b1, 4'd15, "R4", "R4", "R5");
        check("R4", "wrap15", count, 0);
        // R8: count 13 at modulus 16, shrink to modulus 8
        do_reset();
        for (int i = 0; i < 13; i++) step(1'b1, 1'b1, 4'd2, "R3", "R4", "R5");
        step(1'b0, 1'b1, 4'd1, "R8", "R8", "R8");
        check("R8", "reduced", count, 5);
        step(1'b1, 1'b1, 4'd1, "R8", "R8", "R8");
        check("R8", "after", count, 6);
        // R1: reset from a non-zero count
        do_reset();
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [CODE_W-1:0] c;
            int r;
            r = int'($urandom_range(0, 19));
            c = (r == 0) ? 4'd0 : (r == 1) ? 4'd15 : CODE_W'($urandom_range(1, 3));
            if ($urandom_range(0, 99) < 2) do_reset();
            else step($urandom_range(0, 9) != 0, $urandom_range(0, 1) == 1, c, "R3", "R4", "R5");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule